// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This unit sits beside an 8-bit processor core and decides, at each instruction boundary, whether the core must break off into an interrupt service routine and to which 16-bit address it must call. It watches one non-maskable request, three numbered requests, and one general request. The numbered requests come in two kinds. Two of them are level-sensitive. The third is caught on a rising edge and held in a flip-flop.

The core reports the end of each instruction on `boundary_i`. It raises `ei_i` while an enable instruction executes and `di_i` while a disable instruction executes. It raises `sim_wr_i` with the accumulator on `acc_i` when it runs the set-mask instruction, and it copies `rim_o` into the accumulator for the read-mask instruction. When `take_o` is high together with `boundary_i`, the core calls `vec_o`. When `inta_o` is also high, the core runs an acknowledge cycle to fetch the opcode from the requesting device. The unit does not perform the call, stack the return address, or supply that opcode.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the three mask bits are 1, the global enable is 0, the edge latches are clear and `sod_o` is 0. With `ser_in_i` low, `rim_o` then reads 8'h07 and `take_o` stays low.
- R2: `take_o` is high only in a cycle where `boundary_i` is high. It is combinational in that cycle. The vectors are: non-maskable 16'h0024, edge request 16'h003C, high level request 16'h0034, low level request 16'h002C. For the general request, `vec_o` is 16'h0000 and `inta_o` is 1.
- R3: Fixed priority applies from highest to lowest: non-maskable, edge request, high level request, low level request, general request. Only the winner's vector is presented.
- R4: The two level requests are honoured only while the input is high, its mask bit is 0 and the global enable is 1. A request that drops before the boundary leaves no trace. Mask bit 0 belongs to the low level request and mask bit 1 to the high level request.
- R5: A rising edge on `rq75_i` sets a pending latch that persists after the input falls. The latch is served when mask bit 2 is 0 and the global enable is 1. It clears when this request is accepted, or on a set-mask write with `acc_i[4]`=1.
- R6: The non-maskable request ignores the masks and the global enable. It is accepted only if `trap_i` has risen since its last acceptance and is still high at the boundary. Holding the input high does not cause a second acceptance.
- R7: Any acceptance clears the global enable, so `rim_o[3]` reads 0 afterwards.
- R8: A pulse on `ei_i` makes the global enable 1 only at the next boundary, which is the end of the enable instruction. Requests are therefore first honoured at the boundary after that.
- R9: On a set-mask write, `acc_i[2:0]` replaces the masks only when `acc_i[3]` is 1. `sod_o` takes `acc_i[7]` only when `acc_i[6]` is 1.
- R10: `rim_o` reads as follows. Bits [2:0] are the masks. Bit 3 is the global enable. Bit 4 is the `rq55_i` level and bit 5 is the `rq65_i` level. Bit 6 is the edge latch. Bit 7 is `ser_in_i`.
- R11: A pulse on `di_i` clears the global enable and any armed enable at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | End of the current instruction |
| ei_i | input | 1 | Enable instruction executing |
| di_i | input | 1 | Disable instruction executing |
| sim_wr_i | input | 1 | Set-mask instruction writes `acc_i` |
| acc_i | input | 8 | Accumulator value for set-mask |
| trap_i | input | 1 | Non-maskable request |
| rq75_i | input | 1 | Edge-triggered request |
| rq65_i | input | 1 | High-priority level request |
| rq55_i | input | 1 | Low-priority level request |
| intr_i | input | 1 | General request |
| ser_in_i | input | 1 | Serial input bit |
| take_o | output | 1 | Interrupt accepted at this boundary |
| inta_o | output | 1 | Accepted request is the general one |
| vec_o | output | 16 | Call address |
| rim_o | output | 8 | Read-mask word |
| sod_o | output | 1 | Serial output bit |

## Verification
The priority logic is driven with request sets that nest downward from all five active to one. Each set therefore shows that the next lower source wins only once every higher source is absent. Mask patterns that hide a subset of the requests show that a masked source drops out of the arbitration and passes the boundary to the next unmasked one. A masked non-maskable case shows that it ignores the masks. Directed cases separate three request kinds by their timing: a level that falls before the boundary, an edge that falls before the boundary, and a non-maskable level held high across two boundaries. Further directed cases show that the enable takes effect one instruction late, and that the mask-set and output-enable bits gate their writes.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary_i,
  input  logic        ei_i,
  input  logic        di_i,
  input  logic        sim_wr_i,
  input  logic [7:0]  acc_i,
  input  logic        trap_i,
  input  logic        rq75_i,
  input  logic        rq65_i,
  input  logic        rq55_i,
  input  logic        intr_i,
  input  logic        ser_in_i,
  output logic        take_o,
  output logic        inta_o,
  output logic [15:0] vec_o,
  output logic [7:0]  rim_o,
  output logic        sod_o
);
  localparam logic [15:0] V_TRAP = 16'h0024;
  localparam logic [15:0] V_75   = 16'h003C;
  localparam logic [15:0] V_65   = 16'h0034;
  localparam logic [15:0] V_55   = 16'h002C;

  logic [2:0] mask;
  logic ie, ie_arm, lat75, trap_lat, trap_q, r75_q, sod;
  logic go_trap, go75, go65, go55, go_int, fixed_any;

  assign go_trap   = trap_lat & trap_i;
  assign go75      = ie & lat75  & ~mask[2];
  assign go65      = ie & rq65_i & ~mask[1];
  assign go55      = ie & rq55_i & ~mask[0];
  assign go_int    = ie & intr_i;
  assign fixed_any = go_trap | go75 | go65 | go55;

  assign take_o = boundary_i & (fixed_any | go_int);
  assign inta_o = take_o & ~fixed_any;

  always_comb begin
    if (go_trap)   vec_o = V_TRAP;
    else if (go75) vec_o = V_75;
    else if (go65) vec_o = V_65;
    else if (go55) vec_o = V_55;
    else           vec_o = 16'h0000;
  end

  assign rim_o = {ser_in_i, lat75, rq65_i, rq55_i, ie, mask};
  assign sod_o = sod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask     <= 3'b111;
      ie       <= 1'b0;
      ie_arm   <= 1'b0;
      lat75    <= 1'b0;
      trap_lat <= 1'b0;
      trap_q   <= 1'b0;
      r75_q    <= 1'b0;
      sod      <= 1'b0;
    end else begin
      trap_q   <= trap_i;
      r75_q    <= rq75_i;
      trap_lat <= (trap_lat & ~(take_o & go_trap)) | (trap_i & ~trap_q);
      lat75    <= (lat75 & ~(take_o & ~go_trap & go75) & ~(sim_wr_i & acc_i[4]))
                | (rq75_i & ~r75_q);
      if (sim_wr_i && acc_i[3]) mask <= acc_i[2:0];
      if (sim_wr_i && acc_i[6]) sod  <= acc_i[7];
      if (take_o || di_i) begin
        ie     <= 1'b0;
        ie_arm <= 1'b0;
      end else if (ei_i) begin
        ie_arm <= 1'b1;
      end else if (boundary_i && ie_arm) begin
        ie     <= 1'b1;
        ie_arm <= 1'b0;
      end
    end
  end
endmodule

module vec_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary_i,
  input logic        sim_wr_i,
  input logic [7:0]  acc_i,
  input logic        trap_i,
  input logic        rq55_i,
  input logic        take_o,
  input logic        inta_o,
  input logic [15:0] vec_o,
  input logic [7:0]  rim_o,
  input logic        sod_o
);
  p_take_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> boundary_i);
  p_inta_zero_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |-> (take_o && vec_o == 16'h0000));
  p_ie_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !rim_o[3]);
  p_low_level_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == 16'h002C) |-> (rq55_i && !rim_o[0] && rim_o[3]));
  p_trap_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == 16'h0024) |-> trap_i);
  p_sod_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sim_wr_i && acc_i[6]) |=> $stable(sod_o));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .sim_wr_i(sim_wr_i),
  .acc_i(acc_i), .trap_i(trap_i), .rq55_i(rq55_i), .take_o(take_o),
  .inta_o(inta_o), .vec_o(vec_o), .rim_o(rim_o), .sod_o(sod_o)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n, boundary_i, ei_i, di_i, sim_wr_i, trap_i, rq75_i, rq65_i, rq55_i, intr_i, ser_in_i;
  logic [7:0] acc_i;
  logic take_o, inta_o, sod_o;
  logic [15:0] vec_o;
  logic [7:0] rim_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ei_i(ei_i), .di_i(di_i),
    .sim_wr_i(sim_wr_i), .acc_i(acc_i), .trap_i(trap_i), .rq75_i(rq75_i),
    .rq65_i(rq65_i), .rq55_i(rq55_i), .intr_i(intr_i), .ser_in_i(ser_in_i),
    .take_o(take_o), .inta_o(inta_o), .vec_o(vec_o), .rim_o(rim_o), .sod_o(sod_o)
  );

  // {trap, r75, r65, r55, intr, mask[2:0], take, vec[15:0]}
  localparam logic [24:0] TBL [10] = '{
    {5'b11111, 3'b000, 1'b1, 16'h0024},
    {5'b01111, 3'b000, 1'b1, 16'h003C},
    {5'b00111, 3'b000, 1'b1, 16'h0034},
    {5'b00011, 3'b000, 1'b1, 16'h002C},
    {5'b00001, 3'b000, 1'b1, 16'h0000},
    {5'b01110, 3'b111, 1'b0, 16'h0000},
    {5'b11110, 3'b111, 1'b1, 16'h0024},
    {5'b00110, 3'b010, 1'b1, 16'h002C},
    {5'b01000, 3'b011, 1'b1, 16'h003C},
    {5'b00000, 3'b000, 1'b0, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic do_reset;
    rst_n = 0; boundary_i = 0; ei_i = 0; di_i = 0; sim_wr_i = 0; acc_i = 0;
    trap_i = 0; rq75_i = 0; rq65_i = 0; rq55_i = 0; intr_i = 0; ser_in_i = 0;
    tick; tick; rst_n = 1; tick;
  endtask

  task automatic sim_write(input logic [7:0] v);
    sim_wr_i = 1; acc_i = v; tick; sim_wr_i = 0; acc_i = 0;
  endtask

  task automatic enable;
    ei_i = 1; tick; ei_i = 0; boundary_i = 1; tick; boundary_i = 0;
  endtask

  task automatic probe(input string req, input bit et, input logic [15:0] ev);
    boundary_i = 1; #1;
    chk(take_o == et, req, {31'b0, take_o}, {31'b0, et});
    if (et) chk(vec_o == ev, req, {16'b0, vec_o}, {16'b0, ev});
    tick; boundary_i = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset; #1;
    chk(rim_o == 8'h07, "R1", {24'b0, rim_o}, 32'h07);
    chk(sod_o == 0 && take_o == 0, "R1", {30'b0, sod_o, take_o}, 0);

    // R2 R3 R4 priority/mask table
    foreach (TBL[k]) begin
      logic [24:0] e = TBL[k];
      do_reset;
      sim_write({4'b0001, 1'b1, e[19:17]});
      enable;
      {trap_i, rq75_i, rq65_i, rq55_i, intr_i} = e[24:20];
      tick;
      boundary_i = 1; #1;
      chk(take_o == e[16], "R3", {31'b0, take_o}, {31'b0, e[16]});
      if (e[16]) chk(vec_o == e[15:0], "R2", {16'b0, vec_o}, {16'b0, e[15:0]});
      if (e[16] && e[15:0] == 16'h0000) chk(inta_o == 1, "R2", {31'b0, inta_o}, 1);
      tick; boundary_i = 0; #1;
      if (e[16]) chk(rim_o[3] == 0, "R7", {31'b0, rim_o[3]}, 0);
    end

    // R6: trap ignores enable, needs level, fires once
    do_reset;
    trap_i = 1; tick;
    probe("R6", 1, 16'h0024);
    probe("R6", 0, 16'h0000);
    trap_i = 0; tick; trap_i = 1; tick; trap_i = 0; tick;
    probe("R6", 0, 16'h0000);

    // R5: edge latched, served later; cleared by set-mask bit 4
    do_reset; sim_write(8'h08); enable;
    rq75_i = 1; tick; rq75_i = 0; tick; #1;
    chk(rim_o[6] == 1, "R5", {31'b0, rim_o[6]}, 1);
    probe("R5", 1, 16'h003C);
    #1; chk(rim_o[6] == 0, "R5", {31'b0, rim_o[6]}, 0);
    rq75_i = 1; tick; rq75_i = 0; sim_write(8'h10); #1;
    chk(rim_o[6] == 0, "R5", {31'b0, rim_o[6]}, 0);
    enable;
    probe("R5", 0, 16'h0000);

    // R4: level dropped before boundary leaves nothing
    do_reset; sim_write(8'h08); enable;
    rq65_i = 1; tick; rq65_i = 0; tick;
    probe("R4", 0, 16'h0000);

    // R8: enable delayed by one instruction
    do_reset; sim_write(8'h08);
    rq55_i = 1;
    ei_i = 1; tick; ei_i = 0;
    probe("R8", 0, 16'h0000);
    probe("R8", 1, 16'h002C);
    rq55_i = 0;

    // R11: disable clears
    do_reset; sim_write(8'h08); enable;
    di_i = 1; tick; di_i = 0; #1;
    chk(rim_o[3] == 0, "R11", {31'b0, rim_o[3]}, 0);
    rq55_i = 1; tick;
    probe("R11", 0, 16'h0000);
    rq55_i = 0;

    // R9: gated writes
    do_reset;
    sim_write(8'h05); #1;
    chk(rim_o[2:0] == 3'b111, "R9", {29'b0, rim_o[2:0]}, 7);
    sim_write(8'h0D); #1;
    chk(rim_o[2:0] == 3'b101, "R9", {29'b0, rim_o[2:0]}, 5);
    sim_write(8'h80); #1;
    chk(sod_o == 0, "R9", {31'b0, sod_o}, 0);
    sim_write(8'hC0); #1;
    chk(sod_o == 1, "R9", {31'b0, sod_o}, 1);
    sim_write(8'h40); #1;
    chk(sod_o == 0, "R9", {31'b0, sod_o}, 0);

    // R10: read-mask layout
    do_reset; sim_write(8'h0A); enable;
    ser_in_i = 1; rq55_i = 1; rq65_i = 1; #1;
    chk(rim_o == 8'hBA, "R10", {24'b0, rim_o}, 32'hBA);
    ser_in_i = 0; rq55_i = 0; rq65_i = 0; tick;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule